// File: doc/BRIEF.md
# Temperature Alarm with Min/Max Tracking

This block receives temperature codes from an on-chip sensor and watches them. Each accepted sample updates two peak registers, one for the highest reading and one for the lowest. The same sample drives an over-temperature flag. The flag has hysteresis: it rises when a reading goes above a programmable trigger limit. It then stays up until a reading drops below a separate, lower release limit. When power-down is enabled, a power-down request output follows the flag.

Samples are 16-bit words. The 10-bit unsigned code sits in bits 15:6, and bits 5:0 are ignored. The code is computed as (T + 273.15) × 1024 / 503.975, rounded to the nearest integer. The sample input uses valid/ready signalling, but the block never applies back-pressure: ready is held high. Every cycle with valid high therefore transfers one sample.

A synchronous register port gives run-time access to the limits, the control bits and the peak results. It has a 7-bit address, 16-bit write and read data, an enable, a write enable and a ready strobe. The initial values of the limits and of the power-down enable are set by parameters.

Top module: `temp_monitor`

## Requirements
- R1: After reset, over_temp and pwr_down_req are 0. Register reads return: address 0x00 (highest sample) = 0x0000, address 0x01 (lowest sample) = 0xFFFF, address 0x02 (trigger limit) = 0xCA40 (code 809, 125 °C), address 0x03 (release limit) = 0xBD80 (code 758, 100 °C), and address 0x04 (control) = 0x0000.
- R2: smp_ready is 1 in every cycle after reset. Every cycle with smp_valid high delivers one sample.
- R3: Address 0x00 reads back the largest sample code accepted since reset or the last peak clear. The code is returned in bits 15:6, with bits 5:0 read as zero.
- R4: Address 0x01 reads back the smallest sample code accepted since reset or the last peak clear, in the same format as R3.
- R5: A sample whose code (bits 15:6) is strictly greater than the code of the trigger limit sets over_temp. The flag is visible in the cycle after the sample is accepted.
- R6: Once set, over_temp holds until a sample arrives whose code is strictly less than the release-limit code. If the trigger code is at or below the release code, release happens only for a sample whose code is strictly less than the trigger code.
- R7: pwr_down_req equals over_temp AND control bit 0 (power-down enable). It follows a change of either in the same cycle as that change.
- R8: A cycle with reg_en high starts an access. reg_rdy is 1 in the next cycle only. reg_rdata carries the addressed register in that cycle and is 0 in every other cycle.
- R9: reg_we has no effect while reg_en is 0. Reads from unmapped addresses return 0, and writes to them change no register.
- R10: Writing 1 to control bit 1 clears the highest register to 0x0000 and the lowest register to 0xFFFF. The limits, the control enable and over_temp are unchanged, and bit 1 always reads back as 0.
- R11: Writes to addresses 0x02 and 0x03 store the full 16-bit word, which reads back unchanged. The new limit applies to the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, always 1 |
| smp_data | input | 16 | Sample word, code in bits 15:6 |
| reg_en | input | 1 | Register access enable |
| reg_we | input | 1 | Write enable, qualified by reg_en |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid with reg_rdy |
| reg_rdy | output | 1 | Access-complete strobe |
| over_temp | output | 1 | Hysteretic over-temperature flag |
| pwr_down_req | output | 1 | Power-down request |

## Verification
Corrupted peak state shows up only when a register is read back. Stimulus therefore mixes reads in between samples: a wrong peak value is exposed at the next read of address 0x00 or 0x01, within three cycles. The alarm latch is visible directly at over_temp in the cycle after each sample, so a wrong set or release decision appears at once. A wrong release threshold, including the case with inverted limits, is exposed by samples that fall between the two limits. A stale enable or a stuck limit is exposed at pwr_down_req, or by the alarm decision on the next sample.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int DATA_W = 16;
  localparam int CODE_W = 10;
  localparam int ADDR_W = 7;

  localparam logic [ADDR_W-1:0] A_PEAK_HI = 7'h00;
  localparam logic [ADDR_W-1:0] A_PEAK_LO = 7'h01;
  localparam logic [ADDR_W-1:0] A_TRIP    = 7'h02;
  localparam logic [ADDR_W-1:0] A_RELEASE = 7'h03;
  localparam logic [ADDR_W-1:0] A_CTRL    = 7'h04;

  localparam int CTRL_PD_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;
endpackage

// File: rtl/tmon_peak.sv
module tmon_peak #(
  parameter int DW = tmon_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_word,
  input  logic          clr,
  output logic [DW-1:0] hi_word,
  output logic [DW-1:0] lo_word
);
  logic [DW-1:0] peak_q [2];

  // Lane 0 tracks the maximum, lane 1 the minimum.
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam logic [DW-1:0] RST_V = (g == 0) ? '0 : '1;
    logic [DW-1:0] base;
    logic          take;
    assign base = clr ? RST_V : peak_q[g];
    assign take = smp_valid && ((g == 0) ? (smp_word > base) : (smp_word < base));
    always_ff @(posedge clk) begin
      if (!rst_n)    peak_q[g] <= RST_V;
      else if (take) peak_q[g] <= smp_word;
      else           peak_q[g] <= base;
    end
  end

  assign hi_word = peak_q[0];
  assign lo_word = peak_q[1];

  a_r3_max_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> hi_word >= $past(hi_word));
  a_r4_min_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> lo_word <= $past(lo_word));
  a_r10_clear_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !smp_valid) |=> (hi_word == '0 && lo_word == '1));
endmodule

// File: rtl/tmon_alarm.sv
module tmon_alarm #(
  parameter int DW = tmon_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_word,
  input  logic [DW-1:0] trip_word,
  input  logic [DW-1:0] rel_word,
  output logic          alarm
);
  logic [DW-1:0] eff_rel;
  logic          alarm_q;

  // With inverted limits, the trip level also serves as release level.
  assign eff_rel = (trip_word <= rel_word) ? trip_word : rel_word;

  always_ff @(posedge clk) begin
    if (!rst_n) alarm_q <= 1'b0;
    else if (smp_valid) begin
      if (!alarm_q)                alarm_q <= (smp_word > trip_word);
      else if (smp_word < eff_rel) alarm_q <= 1'b0;
    end
  end
  assign alarm = alarm_q;

  a_r5_trip_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_word > trip_word) |=> alarm);
  a_r6_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid) |=> $stable(alarm));
  a_r6_hold_above_release: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && smp_valid && smp_word >= rel_word && smp_word >= trip_word) |=> alarm);
endmodule

// File: rtl/tmon_regs.sv
module tmon_regs #(
  parameter int          DW        = tmon_pkg::DATA_W,
  parameter int          AW        = tmon_pkg::ADDR_W,
  parameter logic [15:0] TRIP_INIT = 16'hCA40,
  parameter logic [15:0] REL_INIT  = 16'hBD80,
  parameter logic        PD_INIT   = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rdy,
  input  logic [DW-1:0] hi_word,
  input  logic [DW-1:0] lo_word,
  output logic [DW-1:0] trip_word,
  output logic [DW-1:0] rel_word,
  output logic          pd_en,
  output logic          peak_clr
);
  import tmon_pkg::*;

  logic          wr;
  logic [DW-1:0] rd_mux;

  assign wr       = reg_en && reg_we;
  assign peak_clr = wr && (reg_addr == A_CTRL) && reg_wdata[CTRL_CLR_BIT];

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      A_PEAK_HI: rd_mux = hi_word;
      A_PEAK_LO: rd_mux = lo_word;
      A_TRIP:    rd_mux = trip_word;
      A_RELEASE: rd_mux = rel_word;
      A_CTRL:    rd_mux[CTRL_PD_BIT] = pd_en;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trip_word <= TRIP_INIT;
      rel_word  <= REL_INIT;
      pd_en     <= PD_INIT;
      reg_rdy   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_rdy   <= reg_en;
      reg_rdata <= reg_en ? rd_mux : '0;
      if (wr) begin
        if (reg_addr == A_TRIP)    trip_word <= reg_wdata;
        if (reg_addr == A_RELEASE) rel_word  <= reg_wdata;
        if (reg_addr == A_CTRL)    pd_en     <= reg_wdata[CTRL_PD_BIT];
      end
    end
  end

  a_r8_rdy_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |=> reg_rdy);
  a_r8_no_rdy_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |=> (!reg_rdy && reg_rdata == '0));
  a_r9_we_ignored_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |=> ($stable(trip_word) && $stable(rel_word) && $stable(pd_en)));
endmodule

// File: rtl/temp_monitor.sv
module temp_monitor #(
  parameter int          DW        = tmon_pkg::DATA_W,
  parameter int          CW        = tmon_pkg::CODE_W,
  parameter int          AW        = tmon_pkg::ADDR_W,
  parameter logic [15:0] TRIP_INIT = 16'hCA40,
  parameter logic [15:0] REL_INIT  = 16'hBD80,
  parameter logic        PD_INIT   = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [DW-1:0] smp_data,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rdy,
  output logic          over_temp,
  output logic          pwr_down_req
);
  localparam logic [DW-1:0] CODE_MASK = {{CW{1'b1}}, {(DW-CW){1'b0}}};

  logic [DW-1:0] smp_m, trip_word, rel_word, hi_word, lo_word;
  logic          pd_en, peak_clr, alarm, rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign smp_ready = rdy_q | rst_n;
  assign smp_m     = smp_data & CODE_MASK;

  tmon_peak #(.DW(DW)) u_peak (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_word(smp_m),
    .clr(peak_clr), .hi_word(hi_word), .lo_word(lo_word)
  );

  tmon_alarm #(.DW(DW)) u_alarm (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_word(smp_m),
    .trip_word(trip_word & CODE_MASK), .rel_word(rel_word & CODE_MASK),
    .alarm(alarm)
  );

  tmon_regs #(.DW(DW), .AW(AW), .TRIP_INIT(TRIP_INIT), .REL_INIT(REL_INIT),
              .PD_INIT(PD_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rdy(reg_rdy), .hi_word(hi_word), .lo_word(lo_word),
    .trip_word(trip_word), .rel_word(rel_word), .pd_en(pd_en),
    .peak_clr(peak_clr)
  );

  assign over_temp    = alarm;
  assign pwr_down_req = alarm & pd_en;

  a_r2_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready);
  a_r10_clear_keeps_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_clr && !smp_valid) |=> $stable(over_temp));
  a_r7_pd_needs_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    !over_temp |-> !pwr_down_req);
endmodule

// File: tb/temp_monitor_tb.sv
module temp_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_rdy;
  logic        over_temp;
  logic        pwr_down_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Bench model state
  logic [15:0] m_hi, m_lo, m_trip, m_rel;
  logic        m_pd, m_alarm;

  always #10 clk = ~clk;

  temp_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rdy(reg_rdy),
    .over_temp(over_temp), .pwr_down_req(pwr_down_req)
  );

  function automatic logic [15:0] word_of(input int code);
    return 16'(code) << 6;
  endfunction

  function automatic int celsius_code(input real t);
    return $rtoi((t + 273.15) * 1024.0 / 503.975 + 0.5);
  endfunction

  function automatic logic next_alarm(input logic a, input logic [15:0] s,
                                      input logic [15:0] tr, input logic [15:0] rl);
    logic [15:0] sm, tm, rm, er;
    sm = s & 16'hFFC0; tm = tr & 16'hFFC0; rm = rl & 16'hFFC0;
    er = (tm <= rm) ? tm : rm;
    if (!a) return sm > tm;
    return !(sm < er);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d, input string req);
    logic [15:0] dm;
    dm = d & 16'hFFC0;
    smp_valid = 1'b1; smp_data = d;
    chk("R2", {31'b0, smp_ready}, 32'd1);
    @(negedge clk);
    smp_valid = 1'b0;
    m_alarm = next_alarm(m_alarm, d, m_trip, m_rel);
    if (dm > m_hi) m_hi = dm;
    if (dm < m_lo) m_lo = dm;
    chk(req, {31'b0, over_temp}, {31'b0, m_alarm});
    chk("R7", {31'b0, pwr_down_req}, {31'b0, m_alarm & m_pd});
  endtask

  task automatic rd(input logic [6:0] a, input logic [15:0] exp, input string req);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    chk("R8", {31'b0, reg_rdy}, 32'd1);
    chk(req, {16'b0, reg_rdata}, {16'b0, exp});
    @(negedge clk);
    chk("R8", {15'b0, reg_rdy, reg_rdata}, 32'd0);
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
    case (a)
      7'h02: m_trip = d;
      7'h03: m_rel = d;
      7'h04: begin
        m_pd = d[0];
        if (d[1]) begin m_hi = 16'h0000; m_lo = 16'hFFFF; end
      end
      default: ;
    endcase
  endtask

  task automatic reset_model;
    m_hi = 16'h0000; m_lo = 16'hFFFF;
    m_trip = 16'hCA40; m_rel = 16'hBD80; m_pd = 1'b0; m_alarm = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd12345));
    reset_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", {30'b0, over_temp, pwr_down_req}, 32'd0);
    chk("R1", {16'b0, m_trip}, {16'b0, word_of(celsius_code(125.0))});
    chk("R1", {16'b0, m_rel}, {16'b0, word_of(celsius_code(100.0))});
    rd(7'h00, 16'h0000, "R1");
    rd(7'h01, 16'hFFFF, "R1");
    rd(7'h02, 16'hCA40, "R1");
    rd(7'h03, 16'hBD80, "R1");
    rd(7'h04, 16'h0000, "R1");

    // R3/R4 first sample overwrites both; low bits dropped
    send(word_of(500) | 16'h003F, "R5");
    rd(7'h00, word_of(500), "R3");
    rd(7'h01, word_of(500), "R4");

    // R5/R6 hysteresis with defaults (trip 809, release 758)
    send(word_of(809), "R5");
    send(word_of(810), "R5");
    send(word_of(780), "R6");
    send(word_of(758), "R6");
    send(word_of(757), "R6");
    send(word_of(800), "R6");

    // R7 power-down follows the enable
    send(word_of(900), "R5");
    wr(7'h04, 16'h0001);
    chk("R7", {31'b0, pwr_down_req}, 32'd1);
    wr(7'h04, 16'h0000);
    chk("R7", {31'b0, pwr_down_req}, 32'd0);
    wr(7'h04, 16'h0001);

    // R10 peak clear leaves limits, enable and alarm alone
    wr(7'h04, 16'h0003);
    chk("R10", {31'b0, over_temp}, 32'd1);
    rd(7'h00, 16'h0000, "R10");
    rd(7'h01, 16'hFFFF, "R10");
    rd(7'h04, 16'h0001, "R10");
    rd(7'h02, 16'hCA40, "R10");
    send(word_of(100), "R6");

    // R9 we without en, unmapped addresses
    reg_we = 1'b1; reg_addr = 7'h02; reg_wdata = 16'h1234;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R9", {31'b0, reg_rdy}, 32'd0);
    rd(7'h02, 16'hCA40, "R9");
    wr(7'h05, 16'hFFFF);
    wr(7'h7F, 16'hFFFF);
    rd(7'h05, 16'h0000, "R9");
    rd(7'h7F, 16'h0000, "R9");
    rd(7'h03, 16'hBD80, "R9");
    rd(7'h04, 16'h0001, "R9");

    // R11 full-word limits, inverted ordering R6
    wr(7'h02, word_of(700) | 16'h0015);
    wr(7'h03, word_of(750) | 16'h002A);
    rd(7'h02, word_of(700) | 16'h0015, "R11");
    rd(7'h03, word_of(750) | 16'h002A, "R11");
    send(word_of(701), "R11");
    send(word_of(720), "R6");
    send(word_of(700), "R6");
    send(word_of(699), "R6");
    wr(7'h02, 16'hCA40);
    wr(7'h03, 16'hBD80);

    // Random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 6) begin
        int c;
        c = (op < 4) ? int'($urandom_range(680, 860)) : int'($urandom_range(0, 1023));
        send(word_of(c) | 16'($urandom_range(0, 63)), "R5");
      end else if (op == 6) begin
        rd(7'h00, m_hi, "R3");
        rd(7'h01, m_lo, "R4");
      end else if (op == 7) begin
        wr(7'h02, word_of(int'($urandom_range(700, 840))));
      end else if (op == 8) begin
        wr(7'h03, word_of(int'($urandom_range(680, 820))));
      end else begin
        wr(7'h04, 16'($urandom_range(0, 3)));
        rd(7'h04, {15'b0, m_pd}, "R10");
      end
    end
    rd(7'h00, m_hi, "R3");
    rd(7'h01, m_lo, "R4");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule